// File: doc/BRIEF.md
# Write-Through Cache Controller

This block is a small cache that sits between a requesting client and a slower backing memory. Both sides use one synchronous request handshake. A request strobe qualifies the cycle, a write flag picks the direction, an address bus and a data bus carry the transfer, and a ready line from the responder ends it. When ready stays low, the requester keeps presenting the identical request. The cache answers a read whose address it holds in the same cycle, with no wait state. It forwards a read miss to memory and keeps the returned word. It sends every write through to memory, and once memory accepts the write it records the new value as well.

Storage is a fully associative array of tag/value entries. A lookup port checks the client address against every valid entry. An update port either overwrites the entry that already holds an address or claims the slot named by a round-robin pointer. A flush input invalidates all entries at once.

Top module: `wt_cache`

## Requirements
- R1: After reset, cl_ready and mem_req are low, and no address is held: the first read of any address goes to memory.
- R2: A read whose address is held completes with cl_ready high in the same cycle it is presented. It returns the held value and makes no memory request.
- R3: A read miss raises mem_req with mem_we low and mem_addr equal to the client address, starting in the cycle after the request is presented.
- R4: A read miss completes in the cycle memory raises mem_ready. cl_rdata equals mem_rdata in that cycle, and the address is held afterwards, so a 2+L cycle miss becomes a 1 cycle hit (L = memory wait cycles).
- R5: Every write, whether its address is held or not, is issued to memory with mem_we high and the client data on mem_wdata. cl_ready is only returned in the cycle mem_ready is high, so a write takes 2+L cycles.
- R6: After a write completes, a read of that address hits and returns the written value.
- R7: A fill of an address already held updates that entry in place and does not move the replacement pointer. Any other fill takes the slot at the pointer, which steps 0,1,...,ENTRIES-1 and then wraps to 0. With 8 entries, the ninth distinct address evicts the first one filled.
- R8: A one-cycle flush invalidates every entry and returns the replacement pointer to slot 0. Reads after a flush miss.
- R9: In a cycle with cl_req low, cl_ready stays low, and while idle no memory request is raised.
- R10: While mem_req is high and mem_ready is low, the next cycle keeps mem_req high with mem_addr, mem_we and mem_wdata unchanged. cl_ready stays low for the whole wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| cl_req | input | 1 | Client request valid |
| cl_we | input | 1 | Client write (1) or read (0) |
| cl_addr | input | ADDR_W | Client address |
| cl_wdata | input | DATA_W | Client write data |
| cl_rdata | output | DATA_W | Read data to client |
| cl_ready | output | 1 | Client request completes this cycle |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Memory request completes this cycle |

## Verification
The bench targets wrap-around of the replacement pointer. A pointer that does not wrap, or that steps on an in-place update, evicts the wrong address, and a later read of an address that should still be held then takes the miss latency. It writes to both held and absent addresses with memory wait states from zero to three. A design that acknowledged a write before memory accepted it would finish in too few cycles, and a design that skipped allocation would miss on the read that follows. A flush followed by a read of a previously written address shows that the written value reached memory and that no stale entry survived. A memory model that stalls also checks that the downstream request never changes mid-wait.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        WTC_IDLE   = 2'd0,
        WTC_MEM_RD = 2'd1,
        WTC_MEM_WR = 2'd2
    } wtc_state_e;
endpackage

// File: rtl/wtc_store.sv
module wtc_store #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][DATA_W-1:0] val;
        logic [PTR_W-1:0]               ptr;
    } store_t;

    store_t q, d;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] st_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = q.valid[g] && (q.tag[g] == lk_addr);
        assign st_match[g] = q.valid[g] && (q.tag[g] == st_addr);
    end

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_data = lk_data | q.val[i];
        end
    end
    assign lk_hit = |lk_match;

    always_comb begin
        d = q;
        if (clear) begin
            d.valid = '0;
            d.ptr   = '0;
        end else if (strobe) begin
            if (|st_match) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (st_match[i]) d.val[i] = st_data;
                end
            end else begin
                d.tag[q.ptr]   = st_addr;
                d.val[q.ptr]   = st_data;
                d.valid[q.ptr] = 1'b1;
                d.ptr          = (q.ptr == LAST) ? '0 : q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_unique_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !lk_hit);
    assert_fill_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clear && lk_addr == st_addr) |=> (lk_addr != $past(st_addr)) || lk_hit);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cl_req,
    input  logic              cl_we,
    input  logic [ADDR_W-1:0] cl_addr,
    input  logic [DATA_W-1:0] cl_wdata,
    output logic [DATA_W-1:0] cl_rdata,
    output logic              cl_ready,
    input  logic              hit,
    input  logic [DATA_W-1:0] hit_data,
    output logic              strobe,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    typedef struct packed {
        wtc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d        = q;
        cl_ready = 1'b0;
        cl_rdata = hit_data;
        strobe   = 1'b0;
        st_addr  = q.addr;
        st_data  = q.data;
        unique case (q.state)
            WTC_IDLE: begin
                if (cl_req) begin
                    if (!cl_we && hit) begin
                        cl_ready = 1'b1;
                    end else begin
                        d.state = cl_we ? WTC_MEM_WR : WTC_MEM_RD;
                        d.addr  = cl_addr;
                        d.data  = cl_wdata;
                    end
                end
            end
            WTC_MEM_RD: begin
                if (mem_ready) begin
                    cl_ready = 1'b1;
                    cl_rdata = mem_rdata;
                    strobe   = 1'b1;
                    st_data  = mem_rdata;
                    d.state  = WTC_IDLE;
                end
            end
            WTC_MEM_WR: begin
                if (mem_ready) begin
                    cl_ready = 1'b1;
                    strobe   = 1'b1;
                    d.state  = WTC_IDLE;
                end
            end
            default: d.state = WTC_IDLE;
        endcase
    end

    assign mem_req   = (q.state != WTC_IDLE);
    assign mem_we    = (q.state == WTC_MEM_WR);
    assign mem_addr  = q.addr;
    assign mem_wdata = q.data;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: WTC_IDLE, addr: '0, data: '0};
        else        q <= d;
    end

    assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    assert_write_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_req && cl_we && cl_ready) |-> (mem_req && mem_we && mem_ready));
    assert_hit_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_req && !cl_we && hit && !mem_req) |-> cl_ready);
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cl_req |-> !cl_ready);
    assert_miss_goes_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_req && !cl_we && !hit && !mem_req) |=> (mem_req && !mem_we && mem_addr == $past(cl_addr)));
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cl_req,
    input  logic              cl_we,
    input  logic [ADDR_W-1:0] cl_addr,
    input  logic [DATA_W-1:0] cl_wdata,
    output logic [DATA_W-1:0] cl_rdata,
    output logic              cl_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    logic              hit;
    logic [DATA_W-1:0] hit_data;
    logic              strobe;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;

    wtc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .lk_addr(cl_addr), .lk_hit(hit), .lk_data(hit_data),
        .strobe(strobe), .st_addr(st_addr), .st_data(st_data)
    );

    wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cl_req(cl_req), .cl_we(cl_we), .cl_addr(cl_addr), .cl_wdata(cl_wdata),
        .cl_rdata(cl_rdata), .cl_ready(cl_ready),
        .hit(hit), .hit_data(hit_data),
        .strobe(strobe), .st_addr(st_addr), .st_data(st_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );
endmodule

// File: tb/wt_cache_bench.sv
module wt_cache_bench;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic cl_req = 1'b0, cl_we = 1'b0;
    logic [AW-1:0] cl_addr = '0;
    logic [DW-1:0] cl_wdata = '0;
    logic [DW-1:0] cl_rdata;
    logic cl_ready, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic mem_ready = 1'b0;

    always #2 clk = ~clk;

    wt_cache #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE)) u_wt_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cl_req(cl_req), .cl_we(cl_we), .cl_addr(cl_addr), .cl_wdata(cl_wdata),
        .cl_rdata(cl_rdata), .cl_ready(cl_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int n_chk = 0, n_bad = 0;
    int lat = 0;
    int mem_ops = 0;
    logic [DW-1:0] mem [64];
    logic [DW-1:0] shadow [64];

    function automatic logic [DW-1:0] init_val(int a);
        return DW'(a * 16'h0131 + 16'h2A07);
    endfunction
    function automatic logic [DW-1:0] wr_val(int a, int k);
        return DW'((a * 16'h0357) ^ (16'hC3A5 + k));
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // memory server with programmable wait states; also checks request hold
    int wcnt = 0;
    bit waiting = 0;
    logic [AW-1:0] h_addr;
    logic h_we;
    logic [DW-1:0] h_wdata;
    always @(negedge clk) begin
        if (waiting) begin
            chk(mem_req && mem_addr == h_addr && mem_we == h_we && mem_wdata == h_wdata,
                "R10", "request held during wait", int'(mem_addr), int'(h_addr));
        end
        waiting = 0;
        if (!rst_n || !mem_req) begin
            wcnt = 0;
            mem_ready = 1'b0;
        end else if (wcnt >= lat) begin
            mem_ready = 1'b1;
            mem_rdata = mem[mem_addr];
            if (mem_we) mem[mem_addr] = mem_wdata;
            mem_ops++;
            wcnt = 0;
        end else begin
            mem_ready = 1'b0;
            wcnt++;
            waiting = 1;
            h_addr = mem_addr; h_we = mem_we; h_wdata = mem_wdata;
        end
    end

    task automatic access(input bit we, input int a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int cyc);
        @(negedge clk);
        cl_req = 1'b1; cl_we = we; cl_addr = AW'(a); cl_wdata = wd;
        cyc = 0; rd = '0;
        forever begin
            #1;
            cyc++;
            if (cl_ready) begin rd = cl_rdata; break; end
            if (cyc > 500) break;
            @(negedge clk);
        end
        @(negedge clk);
        cl_req = 1'b0;
    endtask

    task automatic rd_check(int a, int exp_cyc, string req);
        logic [DW-1:0] rd;
        int cyc;
        access(1'b0, a, '0, rd, cyc);
        chk(cyc == exp_cyc, req, $sformatf("read %0d cycles", a), cyc, exp_cyc);
        chk(rd == shadow[a], req, $sformatf("read %0d data", a), int'(rd), int'(shadow[a]));
    endtask

    task automatic wr_check(int a, logic [DW-1:0] v, string req);
        logic [DW-1:0] rd;
        int cyc;
        access(1'b1, a, v, rd, cyc);
        shadow[a] = v;
        chk(cyc == 2 + lat, req, $sformatf("write %0d cycles", a), cyc, 2 + lat);
        chk(mem[a] == v, req, $sformatf("write %0d reached memory", a), int'(mem[a]), int'(v));
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int ops0;
        for (int a = 0; a < 64; a++) begin mem[a] = init_val(a); shadow[a] = init_val(a); end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!cl_ready, "R1", "cl_ready after reset", int'(cl_ready), 0);
        chk(!mem_req, "R1", "mem_req after reset", int'(mem_req), 0);

        // R1/R3/R4: cold misses, varied wait states
        for (int a = 0; a < NE; a++) begin
            lat = a % 4;
            rd_check(a, 2 + lat, "R4");
        end
        // R2: all resident, no memory traffic
        ops0 = mem_ops;
        for (int a = 0; a < NE; a++) rd_check(a, 1, "R2");
        chk(mem_ops == ops0, "R2", "no memory access on hits", mem_ops, ops0);

        // R7: ninth address evicts slot 0 (addr 0)
        lat = 1;
        rd_check(8, 3, "R7");
        for (int a = 1; a < NE; a++) rd_check(a, 1, "R7");
        rd_check(0, 3, "R7");   // slot1 <- 0, evicts 1
        rd_check(1, 3, "R7");   // slot2 <- 1, evicts 2
        rd_check(8, 1, "R7");

        // R5/R6: write to a held address updates in place (pointer stays 3)
        lat = 2;
        wr_check(0, wr_val(0, 1), "R5");
        rd_check(0, 1, "R6");
        lat = 0;
        wr_check(40, wr_val(40, 1), "R5");   // slot3 <- 40, evicts 3
        rd_check(40, 1, "R6");
        rd_check(4, 1, "R7");                 // in-place write did not step pointer
        rd_check(3, 2, "R7");

        // R9: idle cycles with a held address on the bus
        @(negedge clk);
        cl_addr = AW'(40);
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(!cl_ready, "R9", "cl_ready while idle", int'(cl_ready), 0);
            chk(!mem_req, "R9", "mem_req while idle", int'(mem_req), 0);
            @(negedge clk);
        end

        // R8: flush then everything misses; memory holds written data
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lat = 3;
        rd_check(40, 5, "R8");
        rd_check(0, 5, "R8");
        lat = 0;
        rd_check(8, 2, "R8");

        // sweep: write then read back across the upper addresses
        for (int a = 16; a < 64; a++) begin
            lat = (a * 3) % 4;
            wr_check(a, wr_val(a, 7), "R5");
            rd_check(a, 1, "R6");
        end
        report();
    end
endmodule